// File: doc/BRIEF.md
# Counter Comparison and Event Unit

This block holds a bank of comparison units that all watch one shared timebase counter, the counter the synchronous PWM channels share. Each unit is given a compare value, an enable and a direction qualifier. A unit matches when it is enabled, the counter equals its value, and the counter is moving in a direction the qualifier accepts. When that happens, the unit raises a one-cycle match flag that can serve as an interrupt source.

The match flags are routed through per-line masks onto two event lines. These lines are pulsed to start converter sampling, independently of any PWM output. A separate mask forms a DMA request strobe in the same way. The timebase supplies the counter value, its direction and a period-boundary strobe.

Unit settings arrive on pending configuration inputs. They become active only at a period boundary, so a new compare value never takes effect partway through a period. The routing masks act at once.

Top module: `cmp_event_bank`

## Requirements
- R1: While `rst_n` is low and after reset, all outputs are 0. Every unit starts disabled and stays disabled until the first `period_end` strobe, whatever the pending inputs hold.
- R2: Unit i matches when its active enable is 1, `cnt_val` equals its active value, and its active qualifier accepts the direction. Qualifier bit `2*i` accepts up-counting (`cnt_down`=0) and bit `2*i+1` accepts down-counting (`cnt_down`=1). `match_flag[i]` rises in the clock cycle after the edge at which the match is first seen.
- R3: A match condition that lasts several cycles gives exactly one flag pulse, one cycle long. A new pulse needs the condition to drop and return.
- R4: A unit that is disabled, or whose qualifier rejects the current direction, never raises its flag.
- R5: Pending enable, value and qualifier are copied into the active set only at a clock edge where `period_end` is 1. That edge still compares with the old set. Changes to the pending inputs at other edges have no effect.
- R6: Event line j pulses in the same cycle as the match flags. Its value is the OR of those flags of unit i that have `evt_mask[j*NUM_UNITS+i]` set, with the mask taken at that edge.
- R7: `dma_req` is the OR of the flags of unit i that have `dma_mask[i]` set, with the same timing as R6.
- R8: Units are independent. Several units can flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Shared timebase counter value |
| cnt_down | input | 1 | 1 while the counter counts down |
| period_end | input | 1 | Period boundary strobe, loads pending unit settings |
| cfg_en | input | NUM_UNITS | Pending per-unit enables |
| cfg_val | input | NUM_UNITS*CNT_W | Pending compare values, unit i at bits [i*CNT_W +: CNT_W] |
| cfg_dir | input | 2*NUM_UNITS | Pending direction qualifiers, bit 2i up, bit 2i+1 down |
| evt_mask | input | NUM_LINES*NUM_UNITS | Event line routing masks |
| dma_mask | input | NUM_UNITS | DMA request routing mask |
| match_flag | output | NUM_UNITS | One-cycle match flags |
| evt_pulse | output | NUM_LINES | One-cycle event line pulses |
| dma_req | output | 1 | One-cycle DMA request strobe |

## Verification
The hardest case to reach is a period boundary that arrives in the same cycle as a counter value matching either the old or the new compare value. A related hard case is a counter that stalls on a matching value across that boundary. The stimulus draws counter values and compare values from a small range, holds the counter for random runs of cycles, and strobes `period_end` often. It also flips the direction at random, so that the swap, the hold and the qualifier meet frequently. Directed steps first place each of these situations deliberately.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int DIR_W = 2;

  typedef struct packed {
    logic dn;
    logic up;
  } dir_qual_t;
endpackage

// File: rtl/cmp_unit.sv
module cmp_unit
  import cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             cfg_en_i,
  input  logic [CNT_W-1:0] cfg_val_i,
  input  dir_qual_t        cfg_dir_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  output logic             act_en_o,
  output logic [CNT_W-1:0] act_val_o,
  output logic             hit_new_o
);
  logic             act_en_q, act_en_d;
  logic [CNT_W-1:0] act_val_q, act_val_d;
  dir_qual_t        act_dir_q, act_dir_d;
  logic             hit_prev_q, hit;

  // next-state
  always_comb begin
    act_en_d  = cfg_en_i;
    act_val_d = cfg_val_i;
    act_dir_d = cfg_dir_i;
    hit = act_en_q && (cnt_i == act_val_q) &&
          (cnt_down_i ? act_dir_q.dn : act_dir_q.up);
    hit_new_o = hit && !hit_prev_q;
  end

  // registers, active set gated by the boundary strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en_q   <= 1'b0;
      act_val_q  <= '0;
      act_dir_q  <= '0;
      hit_prev_q <= 1'b0;
    end else begin
      hit_prev_q <= hit;
      if (load_i) begin
        act_en_q  <= act_en_d;
        act_val_q <= act_val_d;
        act_dir_q <= act_dir_d;
      end
    end
  end

  assign act_en_o  = act_en_q;
  assign act_val_o = act_val_q;
endmodule

// File: rtl/cmp_route.sv
module cmp_route #(
  parameter int NUM_UNITS = 8,
  parameter int NUM_LINES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_UNITS-1:0]           hit_new_i,
  input  logic [NUM_LINES*NUM_UNITS-1:0] evt_mask_i,
  input  logic [NUM_UNITS-1:0]           dma_mask_i,
  output logic [NUM_UNITS-1:0]           match_o,
  output logic [NUM_LINES-1:0]           evt_o,
  output logic                           dma_o
);
  logic [NUM_LINES-1:0] evt_d, evt_q;
  logic                 dma_d, dma_q;
  logic [NUM_UNITS-1:0] match_q;

  for (genvar j = 0; j < NUM_LINES; j++) begin : g_line
    always_comb evt_d[j] = |(hit_new_i & evt_mask_i[j*NUM_UNITS +: NUM_UNITS]);
  end

  always_comb dma_d = |(hit_new_i & dma_mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      evt_q   <= '0;
      dma_q   <= 1'b0;
    end else begin
      match_q <= hit_new_i;
      evt_q   <= evt_d;
      dma_q   <= dma_d;
    end
  end

  assign match_o = match_q;
  assign evt_o   = evt_q;
  assign dma_o   = dma_q;
endmodule

// File: rtl/cmp_event_bank.sv
module cmp_event_bank
  import cmp_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int NUM_LINES = 2,
  parameter int CNT_W     = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [CNT_W-1:0]               cnt_val,
  input  logic                           cnt_down,
  input  logic                           period_end,
  input  logic [NUM_UNITS-1:0]           cfg_en,
  input  logic [NUM_UNITS*CNT_W-1:0]     cfg_val,
  input  logic [DIR_W*NUM_UNITS-1:0]     cfg_dir,
  input  logic [NUM_LINES*NUM_UNITS-1:0] evt_mask,
  input  logic [NUM_UNITS-1:0]           dma_mask,
  output logic [NUM_UNITS-1:0]           match_flag,
  output logic [NUM_LINES-1:0]           evt_pulse,
  output logic                           dma_req
);
  logic [NUM_UNITS-1:0]       hit_new;
  logic [NUM_UNITS-1:0]       act_en;
  logic [NUM_UNITS*CNT_W-1:0] act_val;

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    cmp_unit #(.CNT_W(CNT_W)) i_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (period_end),
      .cfg_en_i  (cfg_en[i]),
      .cfg_val_i (cfg_val[i*CNT_W +: CNT_W]),
      .cfg_dir_i (dir_qual_t'(cfg_dir[i*DIR_W +: DIR_W])),
      .cnt_i     (cnt_val),
      .cnt_down_i(cnt_down),
      .act_en_o  (act_en[i]),
      .act_val_o (act_val[i*CNT_W +: CNT_W]),
      .hit_new_o (hit_new[i])
    );
  end

  cmp_route #(.NUM_UNITS(NUM_UNITS), .NUM_LINES(NUM_LINES)) i_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_new_i (hit_new),
    .evt_mask_i(evt_mask),
    .dma_mask_i(dma_mask),
    .match_o   (match_flag),
    .evt_o     (evt_pulse),
    .dma_o     (dma_req)
  );
endmodule

// File: rtl/cmp_event_bank_chk.sv
module cmp_event_bank_chk #(
  parameter int NUM_UNITS = 8,
  parameter int NUM_LINES = 2,
  parameter int CNT_W     = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           period_end,
  input logic [NUM_LINES*NUM_UNITS-1:0] evt_mask,
  input logic [NUM_UNITS-1:0]           dma_mask,
  input logic [NUM_UNITS-1:0]           match_flag,
  input logic [NUM_LINES-1:0]           evt_pulse,
  input logic                           dma_req,
  input logic [NUM_UNITS-1:0]           act_en,
  input logic [NUM_UNITS*CNT_W-1:0]     act_val
);
  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_u
    AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      match_flag[i] |=> !match_flag[i]); // R3
    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      match_flag[i] |-> $past(act_en[i])); // R4
  end

  for (genvar j = 0; j < NUM_LINES; j++) begin : g_l
    AST_EVT_FROM_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse[j] |-> ((match_flag & $past(evt_mask[j*NUM_UNITS +: NUM_UNITS])) != '0)); // R6
  end

  AST_DMA_FROM_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> ((match_flag & $past(dma_mask)) != '0)); // R7

  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(period_end) |-> ($stable(act_en) && $stable(act_val))); // R5
endmodule

bind cmp_event_bank cmp_event_bank_chk #(
  .NUM_UNITS(NUM_UNITS), .NUM_LINES(NUM_LINES), .CNT_W(CNT_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .period_end(period_end),
  .evt_mask  (evt_mask),
  .dma_mask  (dma_mask),
  .match_flag(match_flag),
  .evt_pulse (evt_pulse),
  .dma_req   (dma_req),
  .act_en    (act_en),
  .act_val   (act_val)
);

// File: tb/test_cmp_event_bank.sv
module test_cmp_event_bank;
  localparam int NU = 8;
  localparam int NL = 2;
  localparam int CW = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CW-1:0]     cnt_val;
  logic              cnt_down;
  logic              period_end;
  logic [NU-1:0]     cfg_en;
  logic [NU*CW-1:0]  cfg_val;
  logic [2*NU-1:0]   cfg_dir;
  logic [NL*NU-1:0]  evt_mask;
  logic [NU-1:0]     dma_mask;
  logic [NU-1:0]     match_flag;
  logic [NL-1:0]     evt_pulse;
  logic              dma_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  logic          m_en  [NU];
  logic [CW-1:0] m_val [NU];
  logic          m_up  [NU];
  logic          m_dn  [NU];
  logic          m_prev[NU];
  logic [NU-1:0] e_match;
  logic [NL-1:0] e_evt;
  logic          e_dma;

  always #10ns clk = ~clk;

  cmp_event_bank #(.NUM_UNITS(NU), .NUM_LINES(NL), .CNT_W(CW)) i_cmp_event_bank (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .period_end(period_end), .cfg_en(cfg_en), .cfg_val(cfg_val), .cfg_dir(cfg_dir),
    .evt_mask(evt_mask), .dma_mask(dma_mask), .match_flag(match_flag),
    .evt_pulse(evt_pulse), .dma_req(dma_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NU; i++) begin
      m_en[i] = 0; m_val[i] = '0; m_up[i] = 0; m_dn[i] = 0; m_prev[i] = 0;
    end
    e_match = '0; e_evt = '0; e_dma = 1'b0;
  endtask

  // apply one clock edge to the model using the inputs currently driven
  task automatic model_step();
    logic h;
    for (int i = 0; i < NU; i++) begin
      h = m_en[i] && (cnt_val == m_val[i]) && (cnt_down ? m_dn[i] : m_up[i]);
      e_match[i] = h && !m_prev[i];
      m_prev[i] = h;
    end
    for (int j = 0; j < NL; j++) e_evt[j] = |(e_match & evt_mask[j*NU +: NU]);
    e_dma = |(e_match & dma_mask);
    if (period_end) begin
      for (int i = 0; i < NU; i++) begin
        m_en[i]  = cfg_en[i];
        m_val[i] = cfg_val[i*CW +: CW];
        m_up[i]  = cfg_dir[2*i];
        m_dn[i]  = cfg_dir[2*i+1];
      end
    end
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    model_step();
    chk(tag, 32'(match_flag), 32'(e_match));
    chk("R6", 32'(evt_pulse), 32'(e_evt));
    chk("R7", 32'(dma_req), 32'(e_dma));
    period_end = 1'b0;
  endtask

  task automatic set_unit(input int i, input logic en, input logic [CW-1:0] v,
                          input logic up, input logic dn);
    cfg_en[i] = en;
    cfg_val[i*CW +: CW] = v;
    cfg_dir[2*i] = up;
    cfg_dir[2*i+1] = dn;
  endtask

  task automatic drive_cnt(input logic [CW-1:0] v, input logic dn);
    cnt_val = v; cnt_down = dn;
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cnt_val = '0; cnt_down = 1'b0; period_end = 1'b0;
    cfg_en = '1; cfg_val = '0; cfg_dir = '1;
    evt_mask = '1; dma_mask = '1;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: outputs low in reset even though the counter sits on pending values
    chk("R1", 32'({match_flag, evt_pulse, dma_req}), 32'd0);
    rst_n = 1'b1;
    // R1: units stay disabled until the first boundary
    for (int k = 0; k < 6; k++) begin
      tick("R1");
      drive_cnt(CW'(k % 2), 1'(k % 3 == 0));
    end

    // R2: unit 0 at 5, up only; unit 1 at 5, down only
    cfg_en = '0; cfg_dir = '0;
    evt_mask = '0; evt_mask[0] = 1'b1; evt_mask[NU+1] = 1'b1;
    dma_mask = 8'b0000_0010;
    set_unit(0, 1, 16'd5, 1, 0);
    set_unit(1, 1, 16'd5, 0, 1);
    period_end = 1'b1; drive_cnt(16'd2, 0);
    tick("R2");
    drive_cnt(16'd5, 0); tick("R2");
    drive_cnt(16'd6, 0); tick("R2");
    drive_cnt(16'd5, 1); tick("R2");
    drive_cnt(16'd4, 1); tick("R2");
    tick("R2");

    // R3: counter held on a matching value for several cycles
    drive_cnt(16'd5, 0);
    for (int k = 0; k < 6; k++) tick("R3");
    drive_cnt(16'd7, 0); tick("R3");
    drive_cnt(16'd5, 0); tick("R3");
    tick("R3");

    // R4: disabled unit and rejected direction
    set_unit(0, 0, 16'd9, 1, 1);
    set_unit(1, 1, 16'd9, 0, 0);
    period_end = 1'b1; drive_cnt(16'd0, 0); tick("R4");
    drive_cnt(16'd9, 0); tick("R4");
    drive_cnt(16'd9, 1); tick("R4");
    tick("R4");

    // R5: pending change without a boundary has no effect
    set_unit(2, 1, 16'd3, 1, 1);
    drive_cnt(16'd3, 0); tick("R5");
    drive_cnt(16'd1, 0); tick("R5");
    // boundary edge with a matching count still uses old settings
    period_end = 1'b1; drive_cnt(16'd3, 0); tick("R5");
    drive_cnt(16'd3, 0); tick("R5");
    drive_cnt(16'd2, 0); tick("R5");
    drive_cnt(16'd3, 1); tick("R5");

    // R8: all units on the same value
    for (int i = 0; i < NU; i++) set_unit(i, 1, 16'd11, 1, 1);
    evt_mask = 16'h0F_F0; dma_mask = 8'h81;
    period_end = 1'b1; drive_cnt(16'd0, 0); tick("R8");
    drive_cnt(16'd11, 1); tick("R8");
    drive_cnt(16'd12, 1); tick("R8");

    // randomized mixture
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 1) == 0) cnt_val = CW'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) cnt_down = ~cnt_down;
      period_end = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 5) == 0) begin
        int u = $urandom_range(0, NU-1);
        set_unit(u, 1'($urandom_range(0, 3) != 0), CW'($urandom_range(0, 15)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end
      if ($urandom_range(0, 15) == 0) evt_mask = 16'($urandom);
      if ($urandom_range(0, 15) == 0) dma_mask = 8'($urandom);
      tick("R2");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule